// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block runs one DMA channel through a chain of buffers, each described by a five-word record kept in system memory. Software gives it a start pointer and an enable pulse. For every buffer the channel reads the record over a simple request/acknowledge memory port and loads it into its registers. It then starts an external data mover with the buffer's source, destination, size and second control word. When the mover reports completion, the channel writes the first control word back to the record with a completion flag set. It then follows the record's link field to the next buffer.

The record is laid out as five 32-bit words at offsets +0, +4, +8, +12 and +16: source address, destination address, link to the next record, control word A and control word B. Control word A holds the buffer size in words in bits [15:0], and bit 31 is the completion flag. A link of zero ends the chain.

For buffers after the first, the channel configuration can override the fetched values. The source and destination address registers each have a two-bit mode: 0 or 3 take the fetched word, 1 replays the first buffer's value, and 2 continues contiguously from the previous start address. The configuration also has one flag that replays both control words instead of taking the fetched ones. The channel samples this configuration once, when the chain starts.

Top module: `lli_dma_chan`

## Requirements
- R1: After reset the channel is idle: `busy`, `mem_req`, `mv_start` and `chain_done` are all 0, and while idle it issues no memory request and no mover start.
- R2: A `start` pulse while idle with a nonzero `start_ptr` makes the channel busy. A pulse with `start_ptr` equal to zero is ignored, and the channel stays idle with no memory request.
- R3: For each buffer the channel reads exactly five words, at pointer+0, +4, +8, +12 and +16 in that order. Each request holds its address stable until `mem_ack`.
- R4: After the fifth word arrives, `mv_start` pulses for one cycle. `mv_src`, `mv_dst`, `mv_size` (control A bits [15:0]) and `mv_ctlb` show the buffer's values.
- R5: After `mv_done`, the channel writes control word A with bit 31 set to pointer+12. It makes no memory request between `mv_start` and `mv_done`.
- R6: A nonzero link makes the channel fetch the record at that address next. A zero link ends the chain with a one-cycle `chain_done` pulse, and `busy` is low in that cycle.
- R7: With address mode 0, the source or destination register takes the fetched word for every buffer.
- R8: With address mode 1, every later buffer reuses the first buffer's address.
- R9: With address mode 2, a later buffer's address is the previous buffer's start address plus its size times 4.
- R10: With control replay set, every later buffer uses the first buffer's control words A and B, and the write-back carries the replayed control word A.
- R11: A `start` pulse while the channel is busy is ignored, and the running chain completes unchanged.
- R12: The mode inputs are sampled at the start of a chain. Changes to them during the chain have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Chain enable pulse |
| start_ptr | input | AW | Address of the first record |
| src_mode | input | 2 | Source reload mode (0/3 fetch, 1 replay, 2 contiguous) |
| dst_mode | input | 2 | Destination reload mode (same encoding) |
| ctl_replay | input | 1 | Replay both control words on later buffers |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the request |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | DW | Read data |
| mv_start | output | 1 | One-cycle pulse that starts the data mover |
| mv_src | output | AW | Buffer source address |
| mv_dst | output | AW | Buffer destination address |
| mv_size | output | SIZE_W | Buffer size in words |
| mv_ctlb | output | DW | Control word B of the buffer |
| mv_done | input | 1 | One-cycle pulse when the mover finishes |
| busy | output | 1 | Chain in progress |
| chain_done | output | 1 | One-cycle pulse at the end of the chain |

## Verification
The assertions check, on every cycle, the port-level rules. These are: quiet outputs while idle, held requests with a stable address, single-cycle mover and completion pulses, no memory traffic while the mover runs, the completion flag on every write, and the ignored zero-pointer start. What only the bench scenarios can show is the data content. This covers the order of the five fetch addresses, the following of links, the values the replay and contiguous modes produce over a three-buffer chain, the written-back words, and the fact that a mid-chain start or mode change leaves the result unchanged.

// File: rtl/lli_dma_chan.sv
module lli_dma_chan #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_ptr,
  input  logic [1:0]        src_mode,
  input  logic [1:0]        dst_mode,
  input  logic              ctl_replay,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_ack,
  input  logic [DW-1:0]     mem_rdata,
  output logic              mv_start,
  output logic [AW-1:0]     mv_src,
  output logic [AW-1:0]     mv_dst,
  output logic [SIZE_W-1:0] mv_size,
  output logic [DW-1:0]     mv_ctlb,
  input  logic              mv_done,
  output logic              busy,
  output logic              chain_done
);
  localparam int SH = $clog2(DW / 8);
  localparam logic [1:0] M_REPLAY = 2'd1;
  localparam logic [1:0] M_CONTIG = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RUN, S_WAIT, S_WB} st_t;

  st_t st;
  logic [2:0] idx;
  logic [AW-1:0] ptr, nxt, src, dst;
  logic [DW-1:0] ctla, ctlb;
  logic first, cr, done_q;
  logic [1:0] sm, dm;

  wire [AW-1:0] step = AW'(ctla[SIZE_W-1:0]) << SH;

  function automatic logic [AW-1:0] pick(input logic [1:0] m, input logic fst,
                                         input logic [AW-1:0] cur, input logic [AW-1:0] w,
                                         input logic [AW-1:0] inc);
    if (fst) return w;
    case (m)
      M_REPLAY: return cur;
      M_CONTIG: return cur + inc;
      default:  return w;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; idx <= '0; ptr <= '0; nxt <= '0; src <= '0; dst <= '0;
      ctla <= '0; ctlb <= '0; first <= 1'b0; cr <= 1'b0; sm <= '0; dm <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start && start_ptr != '0) begin
          ptr <= start_ptr; first <= 1'b1; idx <= '0;
          sm <= src_mode; dm <= dst_mode; cr <= ctl_replay;
          st <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          case (idx)
            3'd0: src <= pick(sm, first, src, AW'(mem_rdata), step);
            3'd1: dst <= pick(dm, first, dst, AW'(mem_rdata), step);
            3'd2: nxt <= AW'(mem_rdata);
            3'd3: if (first || !cr) ctla <= mem_rdata;
            default: if (first || !cr) ctlb <= mem_rdata;
          endcase
          idx <= idx + 3'd1;
          if (idx == 3'd4) st <= S_RUN;
        end
        S_RUN:  st <= S_WAIT;
        S_WAIT: if (mv_done) st <= S_WB;
        S_WB: if (mem_ack) begin
          if (nxt == '0) begin
            st <= S_IDLE; done_q <= 1'b1;
          end else begin
            ptr <= nxt; first <= 1'b0; idx <= '0; st <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req    = (st == S_FETCH) || (st == S_WB);
  assign mem_we     = (st == S_WB);
  assign mem_addr   = ptr + (AW'(mem_we ? 3'd3 : idx) << SH);
  assign mem_wdata  = {1'b1, ctla[DW-2:0]};
  assign mv_start   = (st == S_RUN);
  assign mv_src     = src;
  assign mv_dst     = dst;
  assign mv_size    = ctla[SIZE_W-1:0];
  assign mv_ctlb    = ctlb;
  assign busy       = (st != S_IDLE);
  assign chain_done = done_q;
endmodule

// File: rtl/lli_dma_chan_chk.sv
module lli_dma_chan_chk #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int SIZE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [AW-1:0]     start_ptr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [AW-1:0]     mem_addr,
  input logic [DW-1:0]     mem_wdata,
  input logic              mem_ack,
  input logic              mv_start,
  input logic              mv_done,
  input logic              busy,
  input logic              chain_done
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !mv_start); // R1
  AST_ZERO_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && start_ptr == '0 |=> !busy); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R3
  AST_MV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> !mv_start); // R4
  AST_QUIET_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    mv_start |=> !mem_req); // R5
  AST_WB_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[DW-1]); // R5
  AST_DONE_END: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> !busy); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |=> !chain_done); // R6
endmodule

bind lli_dma_chan lli_dma_chan_chk #(.AW(AW), .DW(DW), .SIZE_W(SIZE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .mem_ack(mem_ack), .mv_start(mv_start), .mv_done(mv_done),
  .busy(busy), .chain_done(chain_done));

// File: tb/test_lli_dma_chan.sv
`timescale 1ns/1ps
module test_lli_dma_chan;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, ctl_replay = 1'b0;
  logic [31:0] start_ptr = '0;
  logic [1:0] src_mode = '0, dst_mode = '0;
  logic mem_req, mem_we, mem_ack = 1'b0, mv_start, mv_done = 1'b0, busy, chain_done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0, mv_src, mv_dst, mv_ctlb;
  logic [15:0] mv_size;

  always #5 clk = ~clk;

  lli_dma_chan i_lli_dma_chan (
    .clk(clk), .rst_n(rst_n), .start(start), .start_ptr(start_ptr),
    .src_mode(src_mode), .dst_mode(dst_mode), .ctl_replay(ctl_replay),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mv_start(mv_start), .mv_src(mv_src), .mv_dst(mv_dst), .mv_size(mv_size),
    .mv_ctlb(mv_ctlb), .mv_done(mv_done), .busy(busy), .chain_done(chain_done));

  logic [31:0] mem [0:63];
  logic [31:0] rd_log [0:31];
  logic [31:0] b_src [0:7], b_dst [0:7], b_ctlb [0:7];
  logic [15:0] b_size [0:7];
  int nr = 0, nb = 0, mvcnt = 0;
  logic clr = 1'b0, hw_en = 1'b0;
  logic [5:0] hw_idx = '0;
  logic [31:0] hw_data = '0;
  int checks = 0, fails = 0;

  always @(posedge clk) begin
    if (hw_en) mem[hw_idx] <= hw_data;
    if (clr) begin nr <= 0; nb <= 0; end
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && !mem_ack) begin
      if (mem_we) mem[mem_addr[7:2]] <= mem_wdata;
      else begin
        mem_rdata <= mem[mem_addr[7:2]];
        if (!clr && nr < 32) begin rd_log[nr] <= mem_addr; nr <= nr + 1; end
      end
    end
    mv_done <= (mvcnt == 1);
    if (mv_start) begin
      mvcnt <= 3;
      if (!clr && nb < 8) begin
        b_src[nb] <= mv_src; b_dst[nb] <= mv_dst; b_size[nb] <= mv_size;
        b_ctlb[nb] <= mv_ctlb; nb <= nb + 1;
      end
    end else if (mvcnt != 0) mvcnt <= mvcnt - 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk); hw_en = 1'b1; hw_idx = addr[7:2]; hw_data = data;
    @(negedge clk); hw_en = 1'b0;
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] n, input logic [31:0] a, input logic [31:0] b);
    hwrite(at, s); hwrite(at + 4, d); hwrite(at + 8, n); hwrite(at + 12, a); hwrite(at + 16, b);
  endtask

  task automatic load_all();
    put_desc(32'h40, 32'h1000, 32'h2000, 32'h80, 32'h4, 32'hB0);
    put_desc(32'h80, 32'h1100, 32'h2200, 32'hC0, 32'h8, 32'hB1);
    put_desc(32'hC0, 32'h1300, 32'h2300, 32'h0, 32'h10, 32'hB2);
  endtask

  task automatic pulse_start(input logic [31:0] p);
    @(negedge clk); start = 1'b1; start_ptr = p;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic begin_chain(input logic [31:0] p, input logic [1:0] sm, input logic [1:0] dm,
                             input logic cr);
    load_all();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    src_mode = sm; dst_mode = dm; ctl_replay = cr;
    pulse_start(p);
  endtask

  task automatic wait_done(input string req);
    bit seen = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (chain_done) begin seen = 1'b1; break; end
    end
    chk(req, {31'd0, seen}, 32'd1);
    chk(req, {31'd0, busy}, 32'd0);
  endtask

  task automatic t_reset();
    chk("R1", {28'd0, busy, mem_req, mv_start, chain_done}, 32'd0);
  endtask

  task automatic t_fetch_chain();
    begin_chain(32'h40, 2'd0, 2'd0, 1'b0);
    wait_done("R6");
    chk("R2", {31'd0, nb == 3}, 32'd1);
    chk("R3", nr, 32'd15);
    for (int i = 0; i < 5; i++) chk("R3", rd_log[i], 32'h40 + 4 * i);
    chk("R6", rd_log[5], 32'h80);
    chk("R6", rd_log[10], 32'hC0);
    chk("R7", b_src[1], 32'h1100);
    chk("R7", b_dst[2], 32'h2300);
    chk("R4", {16'd0, b_size[1]}, 32'h8);
    chk("R4", b_ctlb[2], 32'hB2);
    chk("R5", mem[6'h13], 32'h80000004);
    chk("R5", mem[6'h33], 32'h80000010);
  endtask

  task automatic t_replay_contig();
    begin_chain(32'h40, 2'd1, 2'd2, 1'b1);
    wait_done("R6");
    chk("R8", b_src[1], 32'h1000);
    chk("R8", b_src[2], 32'h1000);
    chk("R9", b_dst[1], 32'h2010);
    chk("R9", b_dst[2], 32'h2020);
    chk("R10", {16'd0, b_size[2]}, 32'h4);
    chk("R10", b_ctlb[1], 32'hB0);
    chk("R10", mem[6'h23], 32'h80000004);
  endtask

  task automatic t_zero_start();
    pulse_start(32'h0);
    repeat (4) @(negedge clk);
    chk("R2", {30'd0, busy, mem_req}, 32'd0);
  endtask

  task automatic t_busy_start();
    begin_chain(32'h40, 2'd0, 2'd0, 1'b0);
    repeat (3) @(negedge clk);
    pulse_start(32'h80);
    wait_done("R11");
    chk("R11", nb, 32'd3);
    chk("R11", b_src[0], 32'h1000);
    chk("R11", rd_log[0], 32'h40);
  endtask

  task automatic t_cfg_change();
    begin_chain(32'h40, 2'd2, 2'd0, 1'b0);
    src_mode = 2'd0; dst_mode = 2'd1; ctl_replay = 1'b1;
    wait_done("R12");
    chk("R12", b_src[1], 32'h1010);
    chk("R9", b_src[2], 32'h1030);
    chk("R12", b_dst[2], 32'h2300);
    chk("R12", b_ctlb[1], 32'hB1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_fetch_chain();
        t_replay_contig();
        t_zero_start();
        t_busy_start();
        t_cfg_change();
      end
      begin
        #1ms;
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule